// File: doc/BRIEF.md
# Power Resource State Remapper

This block holds the configuration of a bank of power resources and tracks the operating state of each one. Every resource carries a processor-group mask, a primary and secondary ordering class, a translation byte for low-power requests, and a spare byte that has no effect on the state logic. Software programs these bytes through a simple byte-wide register port, and a power sequencer drives 16-bit command words that move resources between states.

A command word either targets one resource by index or reaches many resources at once. A command that reaches many resources selects them by a group mask and by the two class fields. Before a new state is stored, a request for sleep or off is translated through the target's own translation byte. A request for active or warm reset is stored unchanged. The 4-bit state of every resource is presented in parallel on one output vector.

Top module: `res_state_remapper`

## Requirements
- R1: A synchronous active-high reset sets every resource state to 4'h9 (active), every group byte to 8'hE0, every translation byte to 8'h08, and every class byte and spare byte to 8'h00.
- R2: Byte address = index*4 + offset, with offset 0 the group byte (mask in bits 7:5), 1 the class byte (primary class in bits 2:0, secondary class in bits 4:3), 2 the translation byte, 3 the spare byte. A write takes effect at the clock edge. The read data shows the addressed byte combinationally. An address at or beyond NUM_RES*4 reads 8'h00 and a write to it changes nothing.
- R3: A command with bit 15 clear targets the resource whose index is in bits 12:8, with the requested state in bits 3:0. Only that resource changes, one cycle later. An index at or beyond NUM_RES changes nothing. Resource i occupies bits 4i+3:4i of the state output.
- R4: A command with bit 15 set carries a group mask in bits 14:12, a primary class in bits 10:8, a secondary class in bits 7:6 and a state in bits 3:0. It changes every resource whose group byte shares at least one mask bit and whose two classes both match.
- R5: In a broadcast command, a class value of all ones matches every resource and a value of zero matches none.
- R6: A sleep request (4'h8) stores bits 3:0 of the target's translation byte.
- R7: An off request (4'h0) stores bits 7:4 of the target's translation byte.
- R8: Active (4'h9), warm reset (4'hE) and any other code are stored exactly as requested.
- R9: Without a valid command every state holds. A command in the same cycle as a configuration write is resolved against the configuration held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Configuration byte write strobe |
| regAddr | input | ADDR_W | Configuration byte address (read and write) |
| regWrData | input | 8 | Configuration byte to write |
| regRdData | output | 8 | Addressed configuration byte |
| msgValid | input | 1 | Command word valid |
| msgData | input | 16 | Command word |
| resState | output | NUM_RES*4 | Current state of every resource, 4 bits each |

## Verification
A corrupted class or group byte is visible on the read port in the same cycle it is addressed. It also changes which resources a later broadcast reaches, so the state vector differs one cycle after such a command. A wrong translation nibble appears only when a sleep or off request reaches that resource, which is why the stimulus sends both requests through both kinds of command. The reference model is compared on every clock, so a state that drifts while no command is pending is reported in the cycle it changes.

// File: rtl/rgr_pkg.sv
package rgr_pkg;
  typedef logic [3:0] state_t;

  localparam state_t ST_OFF    = 4'h0;
  localparam state_t ST_SLEEP  = 4'h8;
  localparam state_t ST_ACTIVE = 4'h9;
  localparam state_t ST_WARM   = 4'hE;

  localparam logic [7:0] GRP_RESET   = 8'hE0;
  localparam logic [7:0] REMAP_RESET = 8'h08;

  localparam int IDX_W = 5;

  // Strobes from the decoder to the register bank
  typedef struct packed {
    logic             cfgWr;
    logic [IDX_W-1:0] cfgIdx;
    logic [1:0]       cfgOff;
    logic [7:0]       cfgData;
    logic             rdHit;
    logic [IDX_W-1:0] rdIdx;
    logic [1:0]       rdOff;
    logic             apply;
    logic             bcast;
    logic [IDX_W-1:0] msgIdx;
    logic [2:0]       msgGrp;
    logic [2:0]       msgType;
    logic [1:0]       msgType2;
    state_t           msgState;
  } strobe_t;
endpackage

// File: rtl/rgr_ctrl.sv
module rgr_ctrl
  import rgr_pkg::*;
#(
  parameter int NUM_RES = 8,
  parameter int ADDR_W  = 6
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  logic              msgValid,
  input  logic [15:0]       msgData,
  output strobe_t           strb
);
  localparam logic [ADDR_W:0] BANK_LIM = (ADDR_W+1)'(NUM_RES * 4);
  localparam logic [IDX_W:0]  RES_LIM  = (IDX_W+1)'(NUM_RES);

  logic addrInBank;
  logic idxInBank;
  logic [IDX_W-1:0] addrIdx;
  logic unusedMsgBits;

  assign addrInBank    = {1'b0, regAddr} < BANK_LIM;
  assign addrIdx       = IDX_W'(regAddr >> 2);
  assign idxInBank     = {1'b0, msgData[12:8]} < RES_LIM;
  assign unusedMsgBits = ^{msgData[11], msgData[5:4]};

  always_comb begin
    strb          = '0;
    strb.cfgWr    = regWrEn && addrInBank;
    strb.cfgIdx   = addrIdx;
    strb.cfgOff   = regAddr[1:0];
    strb.cfgData  = regWrData;
    strb.rdHit    = addrInBank;
    strb.rdIdx    = addrIdx;
    strb.rdOff    = regAddr[1:0];
    strb.bcast    = msgData[15];
    strb.apply    = msgValid && (msgData[15] || idxInBank);
    strb.msgIdx   = msgData[12:8];
    strb.msgGrp   = msgData[14:12];
    strb.msgType  = msgData[10:8];
    strb.msgType2 = msgData[7:6];
    strb.msgState = msgData[3:0];
  end
endmodule

// File: rtl/rgr_datapath.sv
module rgr_datapath
  import rgr_pkg::*;
#(
  parameter int NUM_RES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  strobe_t              strb,
  output logic [NUM_RES*4-1:0] resState,
  output logic [7:0]           rdData
);
  localparam int ST_W = 4;

  logic [7:0] grpR   [NUM_RES];
  logic [7:0] typR   [NUM_RES];
  logic [7:0] remapR [NUM_RES];
  logic [7:0] dedR   [NUM_RES];

  logic [NUM_RES-1:0]      selVec;
  logic [NUM_RES*ST_W-1:0] tgtVec;

  generate
    for (genvar g = 0; g < NUM_RES; g++) begin : g_res
      logic grpHit, typHit, typ2Hit, idxHit;
      assign grpHit  = |(strb.msgGrp & grpR[g][7:5]);
      assign typHit  = (strb.msgType == 3'b111) ||
                       ((strb.msgType != 3'b000) && (strb.msgType == typR[g][2:0]));
      assign typ2Hit = (strb.msgType2 == 2'b11) ||
                       ((strb.msgType2 != 2'b00) && (strb.msgType2 == typR[g][4:3]));
      assign idxHit  = strb.msgIdx == IDX_W'(g);
      assign selVec[g] = strb.apply &&
                         (strb.bcast ? (grpHit && typHit && typ2Hit) : idxHit);
      assign tgtVec[g*ST_W +: ST_W] =
          (strb.msgState == ST_SLEEP) ? remapR[g][3:0] :
          (strb.msgState == ST_OFF)   ? remapR[g][7:4] :
                                        strb.msgState;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_RES; i++) begin
        grpR[i]   <= GRP_RESET;
        typR[i]   <= 8'h00;
        remapR[i] <= REMAP_RESET;
        dedR[i]   <= 8'h00;
        resState[i*ST_W +: ST_W] <= ST_ACTIVE;
      end
    end else begin
      for (int i = 0; i < NUM_RES; i++) begin
        if (strb.cfgWr && (strb.cfgIdx == IDX_W'(i))) begin
          case (strb.cfgOff)
            2'd0:    grpR[i]   <= strb.cfgData;
            2'd1:    typR[i]   <= strb.cfgData;
            2'd2:    remapR[i] <= strb.cfgData;
            default: dedR[i]   <= strb.cfgData;
          endcase
        end
        if (selVec[i]) begin
          resState[i*ST_W +: ST_W] <= tgtVec[i*ST_W +: ST_W];
        end
      end
    end
  end

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < NUM_RES; i++) begin
      if (strb.rdHit && (strb.rdIdx == IDX_W'(i))) begin
        case (strb.rdOff)
          2'd0:    rdData = grpR[i];
          2'd1:    rdData = typR[i];
          2'd2:    rdData = remapR[i];
          default: rdData = dedR[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/res_state_remapper.sv
module res_state_remapper
  import rgr_pkg::*;
#(
  parameter int NUM_RES = 8,
  parameter int ADDR_W  = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [7:0]           regWrData,
  output logic [7:0]           regRdData,
  input  logic                 msgValid,
  input  logic [15:0]          msgData,
  output logic [NUM_RES*4-1:0] resState
);
  strobe_t strb;

  rgr_ctrl #(.NUM_RES(NUM_RES), .ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .msgValid (msgValid),
    .msgData  (msgData),
    .strb     (strb)
  );

  rgr_datapath #(.NUM_RES(NUM_RES)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .resState(resState),
    .rdData  (regRdData)
  );
endmodule

// File: rtl/res_state_remapper_chk.sv
module res_state_remapper_chk #(
  parameter int NUM_RES = 8,
  parameter int ADDR_W  = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 regWrEn,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [7:0]           regWrData,
  input logic [7:0]           regRdData,
  input logic                 msgValid,
  input logic [15:0]          msgData,
  input logic [NUM_RES*4-1:0] resState
);
  logic inRange;
  logic idxOk;
  assign inRange = {1'b0, regAddr} < (ADDR_W+1)'(NUM_RES * 4);
  assign idxOk   = {1'b0, msgData[12:8]} < 6'(NUM_RES);

  p_reset_active_r1: assert property (@(posedge clk)
    rst |=> (resState == {NUM_RES{4'h9}}));

  p_readback_r2: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && inRange) |=>
      ((regAddr != $past(regAddr)) || (regRdData == $past(regWrData))));

  p_singular_active_r3: assert property (@(posedge clk) disable iff (rst)
    (msgValid && !msgData[15] && idxOk && (msgData[3:0] == 4'h9)) |=>
      (resState[int'($past(msgData[12:8]))*4 +: 4] == 4'h9));

  p_zero_class_none_r5: assert property (@(posedge clk) disable iff (rst)
    (msgValid && msgData[15] && (msgData[10:8] == 3'b000)) |=> $stable(resState));

  p_warm_unchanged_r8: assert property (@(posedge clk) disable iff (rst)
    (msgValid && !msgData[15] && idxOk && (msgData[3:0] == 4'hE)) |=>
      (resState[int'($past(msgData[12:8]))*4 +: 4] == 4'hE));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !msgValid |=> $stable(resState));
endmodule

bind res_state_remapper res_state_remapper_chk #(.NUM_RES(NUM_RES), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .msgValid (msgValid),
  .msgData  (msgData),
  .resState (resState)
);

// File: tb/res_state_remapper_tb.sv
module res_state_remapper_tb;
  localparam int NUM_RES = 8;
  localparam int ADDR_W  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic msgValid = 1'b0;
  logic [15:0] msgData = '0;
  logic [NUM_RES*4-1:0] resState;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  res_state_remapper #(.NUM_RES(NUM_RES), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .msgValid(msgValid),
    .msgData(msgData), .resState(resState)
  );

  // Behavioural reference model
  logic [7:0] mGrp [NUM_RES];
  logic [7:0] mTyp [NUM_RES];
  logic [7:0] mRmp [NUM_RES];
  logic [7:0] mDed [NUM_RES];
  logic [3:0] mSt  [NUM_RES];

  always @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_RES; r++) begin
        mGrp[r] = 8'hE0; mTyp[r] = 8'h00; mRmp[r] = 8'h08; mDed[r] = 8'h00; mSt[r] = 4'h9;
      end
    end else begin
      if (msgValid) begin
        for (int r = 0; r < NUM_RES; r++) begin
          bit hit;
          int t, t2, req;
          t = int'(msgData[10:8]);
          t2 = int'(msgData[7:6]);
          req = int'(msgData[3:0]);
          if (msgData[15])
            hit = ((msgData[14:12] & mGrp[r][7:5]) != 0) &&
                  (t == 7 || (t != 0 && t == int'(mTyp[r][2:0]))) &&
                  (t2 == 3 || (t2 != 0 && t2 == int'(mTyp[r][4:3])));
          else
            hit = (int'(msgData[12:8]) == r);
          if (hit) begin
            if (req == 8) mSt[r] = mRmp[r][3:0];
            else if (req == 0) mSt[r] = mRmp[r][7:4];
            else mSt[r] = 4'(req);
          end
        end
      end
      if (regWrEn && int'(regAddr) < NUM_RES*4) begin
        case (int'(regAddr) % 4)
          0: mGrp[int'(regAddr)/4] = regWrData;
          1: mTyp[int'(regAddr)/4] = regWrData;
          2: mRmp[int'(regAddr)/4] = regWrData;
          default: mDed[int'(regAddr)/4] = regWrData;
        endcase
      end
    end
  end

  function automatic logic [7:0] modelRd(int a);
    if (a >= NUM_RES*4) return 8'h00;
    case (a % 4)
      0: return mGrp[a/4];
      1: return mTyp[a/4];
      2: return mRmp[a/4];
      default: return mDed[a/4];
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [NUM_RES*4-1:0] exp;
      for (int r = 0; r < NUM_RES; r++) exp[r*4 +: 4] = mSt[r];
      checks++;
      if (resState !== exp) begin
        errors++;
        $display("FAIL MODEL state: actual %h expected %h", resState, exp);
      end
      checks++;
      if (regRdData !== modelRd(int'(regAddr))) begin
        errors++;
        $display("FAIL MODEL read @%0d: actual %h expected %h", regAddr, regRdData, modelRd(int'(regAddr)));
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(posedge clk); #2;
    regWrEn = 1'b1; regAddr = ADDR_W'(a); regWrData = d;
    @(posedge clk); #2;
    regWrEn = 1'b0;
  endtask

  task automatic msg(logic [15:0] m);
    @(posedge clk); #2;
    msgValid = 1'b1; msgData = m;
    @(posedge clk); #2;
    msgValid = 1'b0;
  endtask

  task automatic rd(string tag, int a, logic [7:0] exp);
    @(posedge clk); #2;
    regAddr = ADDR_W'(a);
    @(negedge clk);
    check(tag, 32'(regRdData), 32'(exp));
  endtask

  task automatic st(string tag, logic [31:0] exp);
    @(negedge clk);
    check(tag, resState, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    // R1 reset values
    st("R1 states", 32'h99999999);
    rd("R1 group", 0, 8'hE0);
    rd("R1 class", 1, 8'h00);
    rd("R1 remap", 2, 8'h08);
    rd("R1 spare", 3, 8'h00);
    // R2 register map
    wr(9, 8'h13); wr(10, 8'h5C); wr(11, 8'hA5); wr(1, 8'h09);
    rd("R2 class res2", 9, 8'h13);
    rd("R2 remap res2", 10, 8'h5C);
    rd("R2 spare res2", 11, 8'hA5);
    wr(40, 8'hFF);
    rd("R2 out of bank", 40, 8'h00);
    rd("R2 neighbour untouched", 8, 8'hE0);
    // Singular commands
    msg(16'h0008); st("R6 sleep res0", 32'h99999998);
    msg(16'h0100); st("R7 off res1", 32'h99999908);
    msg(16'h0208); st("R6 sleep remap res2", 32'h99999C08);
    msg(16'h030E); st("R8 warm res3", 32'h9999EC08);
    msg(16'h0109); st("R8 active res1", 32'h9999EC98);
    msg(16'h0900); st("R3 index out of range", 32'h9999EC98);
    // Broadcast selection
    msg(16'hF380); st("R4 class match off", 32'h9999E598);
    msg(16'hF0C9); st("R5 zero class none", 32'h9999E598);
    msg(16'hF709); st("R5 zero class2 none", 32'h9999E598);
    wr(0, 8'h20);
    msg(16'hA7C9); st("R4 group mask miss", 32'h99999998);
    msg(16'hF7C8); st("R5 wildcard sleep", 32'h88888C88);
    // R9 same-cycle write and command
    @(posedge clk); #2;
    regWrEn = 1'b1; regAddr = ADDR_W'(6); regWrData = 8'h30;
    msgValid = 1'b1; msgData = 16'h0100;
    @(posedge clk); #2;
    regWrEn = 1'b0; msgValid = 1'b0;
    st("R9 old remap used", 32'h88888C08);
    repeat (3) @(posedge clk);
    st("R9 idle hold", 32'h88888C08);
    msg(16'h0100); st("R9 new remap used", 32'h88888C38);
    msg(16'h070E); st("R3 top slot", 32'hE8888C38);
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule